// File: doc/BRIEF.md
# Masked Time-of-Day Alarm and Interrupt Unit

This block sits beside a BCD clock and raises an alarm when the current time agrees with a programmed alarm time. Four alarm registers hold a seconds, a minutes, an hours and a date value. Bit 7 of each register is a mask bit. Together the four mask bits choose how often the alarm fires: every second, or when one, two, three or all four fields agree. The comparison runs once for each seconds tick. A hit sets an alarm flag. If the enables allow it, the hit also pulls the shared interrupt pin low. In battery-backup mode a second enable must also be set.

Any access to the flags register, read or write, releases the pin. The flag stays readable for the whole of that access and clears once the access ends. Under a test condition the same pin carries a square wave at half the rate of a 1024 Hz strobe, which gives 512 Hz. The pin is modelled as an open-drain enable: 1 means pull low, 0 means high impedance.

Top module: `tod_alarm_irq`

## Requirements
- R1: After reset, the alarm registers, the interrupt-control register (including its enable bits) and the alarm flag are all 0, and irq_drive_low is 0.
- R2: A write stores all 8 bits at the alarm registers (address 2 seconds, 3 minutes, 4 hours, 5 date) and at the interrupt-control register (address 6), and a read returns those bits. Reads of any address the block does not own return 0.
- R3: The mask bit is bit 7 of registers 2, 3, 4 and 5 (AM1 through AM4). Only bits 6:0 of each field are compared. With AM4..AM1 = 1111 the alarm hits on every tick, with 1110 when the seconds agree, with 1100 when minutes and seconds agree, with 1000 when hours, minutes and seconds agree, and with 0000 when all four fields agree. Nothing hits in a cycle without sec_tick.
- R4: Any mask pattern not listed in R3 hits on every tick.
- R5: A hit sets the alarm flag (bit 6 of flags register 0) in the cycle after the tick, whatever the enables hold.
- R6: In normal mode, a pending hit drives irq_drive_low to 1 only while alarm-enable (bit 7 of register 6) is 1.
- R7: While backup_mode is 1, a pending hit drives the pin only if alarm-enable and backup-enable (bit 5 of register 6) are both 1.
- R8: A read or write of address 0 releases the interrupt from the cycle after the access begins. The flag keeps reading 1 during that access and becomes 0 in the cycle after the access ends.
- R9: Flags register 0 reads the watchdog-flag input in bit 7 and the battery-low input in bit 4. Bits 5 and 3:0 read 0, and writes to address 0 change nothing.
- R10: When ft_bit is 1, alarm-enable is 0, and wd_steer or wd_reg_zero is 1, the pin starts released and toggles on each tick_1k strobe. When that condition is false, the square wave holds released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current date, BCD |
| backup_mode | input | 1 | 1 while running from battery |
| tick_1k | input | 1 | 1024 Hz strobe for the test square wave |
| ft_bit | input | 1 | Frequency-test control bit |
| wd_steer | input | 1 | Watchdog steering bit |
| wd_reg_zero | input | 1 | Watchdog register is 00h |
| wd_flag | input | 1 | Watchdog flag, shown in flags bit 7 |
| batt_low | input | 1 | Battery-low flag, shown in flags bit 4 |
| bus_sel | input | 1 | Register select, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq_drive_low | output | 1 | Open-drain enable: 1 pulls the interrupt pin low |

## Verification
On every cycle the assertions check these relations: a rising flag must follow a tick, and a cleared enable keeps the pin released. In backup mode a missing backup-enable does the same. A flags access releases the alarm interrupt, the fixed-zero flag bits stay zero, and the test square wave toggles after each strobe. Only the directed scenarios can show the rest. These are the rate chosen by each of the five mask patterns and the fallback for invalid ones, and that the flag clears only after the access ends. They also show register read-back and that writes to the flags register are ignored.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

    localparam int DW     = 8;
    localparam int AW     = 4;
    localparam int FIELDS = 4;   // 0 sec, 1 min, 2 hour, 3 date
    localparam int CMP_W  = 7;   // bits compared per field

    localparam logic [AW-1:0] ADDR_FLAGS    = 4'h0;
    localparam logic [AW-1:0] ADDR_ALM_BASE = 4'h2;
    localparam logic [AW-1:0] ADDR_INTR     = 4'h6;

    localparam int MASK_BIT  = 7;
    localparam int INTR_AE   = 7;
    localparam int INTR_ABE  = 5;
    localparam int FLG_WF    = 7;
    localparam int FLG_AF    = 6;
    localparam int FLG_BL    = 4;

    typedef logic [FIELDS-1:0][DW-1:0] field_vec_t;

    typedef struct packed {
        field_vec_t     alm;
        logic [DW-1:0]  intr;
        logic           af;
        logic           pend;
        logic           flag_acc;
    } alarm_state_t;

    // Which fields must agree for a given mask pattern (bit i = field i).
    function automatic logic [3:0] need_match(input logic [3:0] mask);
        case (mask)
            4'b1111: need_match = 4'b0000;
            4'b1110: need_match = 4'b0001;
            4'b1100: need_match = 4'b0011;
            4'b1000: need_match = 4'b0111;
            4'b0000: need_match = 4'b1111;
            default: need_match = 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
    import tod_alarm_pkg::*;
(
    input  field_vec_t alm_regs,
    input  field_vec_t cur_time,
    output logic       hit
);
    logic [FIELDS-1:0] field_eq;
    logic [FIELDS-1:0] mask;
    logic [FIELDS-1:0] need;

    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        assign field_eq[g] = (alm_regs[g][CMP_W-1:0] == cur_time[g][CMP_W-1:0]);
        assign mask[g]     = alm_regs[g][MASK_BIT];
    end

    assign need = need_match(mask);
    assign hit  = &(field_eq | ~need);

endmodule

// File: rtl/tod_sq_gen.sv
module tod_sq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    output logic level
);
    logic level_d, level_q;

    always_comb begin
        level_d = level_q;
        if (!enable)
            level_d = 1'b1;
        else if (tick)
            level_d = ~level_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            level_q <= 1'b1;
        else
            level_q <= level_d;
    end

    assign level = level_q;

endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq
    import tod_alarm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic [DW-1:0] cur_sec,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    input  logic [DW-1:0] cur_date,
    input  logic          backup_mode,
    input  logic          tick_1k,
    input  logic          ft_bit,
    input  logic          wd_steer,
    input  logic          wd_reg_zero,
    input  logic          wd_flag,
    input  logic          batt_low,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_drive_low
);
    alarm_state_t s_d, s_q;

    field_vec_t cur_time;
    logic       hit;
    logic       access, acc_flags, wr_en;
    logic       alarm_en, backup_en, alarm_flag;
    logic       ft_on, sq_level;

    assign cur_time   = {cur_date, cur_hour, cur_min, cur_sec};
    assign access     = bus_sel & (bus_wr | bus_rd);
    assign acc_flags  = access & (bus_addr == ADDR_FLAGS);
    assign wr_en      = bus_sel & bus_wr;
    assign alarm_en   = s_q.intr[INTR_AE];
    assign backup_en  = s_q.intr[INTR_ABE];
    assign alarm_flag = s_q.af;
    assign ft_on      = ft_bit & ~alarm_en & (wd_steer | wd_reg_zero);

    tod_alarm_cmp u_cmp (
        .alm_regs (s_q.alm),
        .cur_time (cur_time),
        .hit      (hit)
    );

    tod_sq_gen u_sq (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (ft_on),
        .tick   (tick_1k),
        .level  (sq_level)
    );

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < FIELDS; i++) begin
            if (wr_en && bus_addr == ADDR_ALM_BASE + AW'(i))
                s_d.alm[i] = bus_wdata;
        end
        if (wr_en && bus_addr == ADDR_INTR)
            s_d.intr = bus_wdata;
        s_d.flag_acc = acc_flags;
        if (s_q.flag_acc && !acc_flags)
            s_d.af = 1'b0;
        if (acc_flags)
            s_d.pend = 1'b0;
        if (sec_tick && hit) begin
            s_d.af   = 1'b1;
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_FLAGS) begin
            bus_rdata[FLG_WF] = wd_flag;
            bus_rdata[FLG_AF] = s_q.af;
            bus_rdata[FLG_BL] = batt_low;
        end else if (bus_addr == ADDR_INTR) begin
            bus_rdata = s_q.intr;
        end else begin
            for (int i = 0; i < FIELDS; i++) begin
                if (bus_addr == ADDR_ALM_BASE + AW'(i))
                    bus_rdata = s_q.alm[i];
            end
        end
    end

    assign irq_drive_low = (s_q.pend & alarm_en & (~backup_mode | backup_en))
                         | (ft_on & ~sq_level);

endmodule

// File: rtl/tod_alarm_irq_chk.sv
module tod_alarm_irq_chk
    import tod_alarm_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          sec_tick,
    input logic          backup_mode,
    input logic          tick_1k,
    input logic          ft_bit,
    input logic          wd_steer,
    input logic          wd_reg_zero,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_rdata,
    input logic          irq_drive_low,
    input logic          ae,
    input logic          abe,
    input logic          af
);
    logic flags_touch;
    logic ft_cond;

    assign flags_touch = bus_sel && (bus_wr || bus_rd) && (bus_addr == ADDR_FLAGS);
    assign ft_cond     = ft_bit && !ae && (wd_steer || wd_reg_zero);

    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af) |-> $past(sec_tick)); // R5

    AST_AE_GATES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ae && !ft_cond) |-> !irq_drive_low); // R6

    AST_BACKUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (backup_mode && ae && !abe) |-> !irq_drive_low); // R7

    AST_FLAGS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flags_touch) && !$past(sec_tick) && ae) |-> !irq_drive_low); // R8

    AST_FLAG_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_FLAGS) |-> (bus_rdata[5] == 1'b0 && bus_rdata[3:0] == 4'h0)); // R9

    AST_FT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ft_cond && $past(ft_cond) && $past(tick_1k)) |-> (irq_drive_low != $past(irq_drive_low))); // R10

endmodule

bind tod_alarm_irq tod_alarm_irq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sec_tick      (sec_tick),
    .backup_mode   (backup_mode),
    .tick_1k       (tick_1k),
    .ft_bit        (ft_bit),
    .wd_steer      (wd_steer),
    .wd_reg_zero   (wd_reg_zero),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .irq_drive_low (irq_drive_low),
    .ae            (alarm_en),
    .abe           (backup_en),
    .af            (alarm_flag)
);

// File: tb/tod_alarm_irq_bench.sv
module tod_alarm_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
    logic       backup_mode = 1'b0;
    logic       tick_1k = 1'b0;
    logic       ft_bit = 1'b0, wd_steer = 1'b0, wd_reg_zero = 1'b0;
    logic       wd_flag = 1'b0, batt_low = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_drive_low;

    int tests = 0;
    int failed = 0;

    always #5 clk = ~clk;

    tod_alarm_irq u_tod_alarm_irq (.*);

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_pin(input string tag, input logic exp);
        check8(tag, {7'b0, irq_drive_low}, {7'b0, exp});
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic clear_flags();
        logic [7:0] tmp;
        read_reg(4'h0, tmp);
        @(negedge clk);
    endtask

    task automatic set_alarm(input logic [7:0] s, input logic [7:0] m,
                             input logic [7:0] h, input logic [7:0] d);
        write_reg(4'h2, s); write_reg(4'h3, m);
        write_reg(4'h4, h); write_reg(4'h5, d);
    endtask

    task automatic tick(input logic [7:0] s, input logic [7:0] m,
                        input logic [7:0] h, input logic [7:0] d);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = d; sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        #1;
    endtask

    task automatic pulse_1k();
        @(negedge clk);
        tick_1k = 1'b1;
        @(negedge clk);
        tick_1k = 1'b0;
        #1;
    endtask

    // AF is flags bit 6
    task automatic expect_flag(input string tag, input logic exp);
        logic [7:0] v;
        read_reg(4'h0, v);
        check8(tag, v & 8'h40, exp ? 8'h40 : 8'h00);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check_pin("R1 pin released", 1'b0);
        read_reg(4'h0, v); check8("R1 flags", v, 8'h00);
        read_reg(4'h6, v); check8("R1 intr reg", v, 8'h00);
        read_reg(4'h2, v); check8("R1 alarm sec", v, 8'h00);
        read_reg(4'h5, v); check8("R1 alarm date", v, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        write_reg(4'h3, 8'h5A); read_reg(4'h3, v); check8("R2 alarm min", v, 8'h5A);
        write_reg(4'h6, 8'h25); read_reg(4'h6, v); check8("R2 intr reg", v, 8'h25);
        read_reg(4'h9, v); check8("R2 unmapped", v, 8'h00);
        write_reg(4'h6, 8'h00);
    endtask

    task automatic t_masks();
        clear_flags();
        // 1111: every tick
        set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
        tick(8'h11, 8'h22, 8'h03, 8'h04);
        expect_flag("R3 mask 1111", 1'b1);
        check_pin("R6 AE clear keeps pin released", 1'b0);
        // 1110: seconds
        set_alarm(8'h30, 8'h80, 8'h80, 8'h80);
        tick(8'h29, 8'h00, 8'h00, 8'h01); expect_flag("R3 1110 miss", 1'b0);
        tick(8'h30, 8'h45, 8'h12, 8'h09); expect_flag("R3 1110 hit", 1'b1);
        // 1100: minutes and seconds
        set_alarm(8'h15, 8'h42, 8'h80, 8'h80);
        tick(8'h15, 8'h41, 8'h00, 8'h01); expect_flag("R3 1100 miss", 1'b0);
        tick(8'h15, 8'h42, 8'h07, 8'h02); expect_flag("R3 1100 hit", 1'b1);
        // 1000: hours, minutes, seconds
        set_alarm(8'h15, 8'h42, 8'h23, 8'h80);
        tick(8'h15, 8'h42, 8'h22, 8'h01); expect_flag("R3 1000 miss", 1'b0);
        tick(8'h15, 8'h42, 8'h23, 8'h31); expect_flag("R3 1000 hit", 1'b1);
        // 0000: all four
        set_alarm(8'h15, 8'h42, 8'h23, 8'h17);
        tick(8'h15, 8'h42, 8'h23, 8'h18); expect_flag("R3 0000 miss", 1'b0);
        tick(8'h15, 8'h42, 8'h23, 8'h17); expect_flag("R3 0000 hit", 1'b1);
        // matching values without a tick
        @(negedge clk);
        cur_sec = 8'h15; cur_min = 8'h42; cur_hour = 8'h23; cur_date = 8'h17;
        repeat (4) @(negedge clk);
        expect_flag("R3 no tick no hit", 1'b0);
    endtask

    task automatic t_invalid();
        // AM4..AM1 = 0101
        set_alarm(8'h80, 8'h00, 8'h80, 8'h00);
        tick(8'h01, 8'h02, 8'h03, 8'h04);
        expect_flag("R4 invalid 0101 fires", 1'b1);
        // AM4..AM1 = 0011
        set_alarm(8'h80, 8'h80, 8'h00, 8'h00);
        tick(8'h59, 8'h59, 8'h09, 8'h28);
        expect_flag("R4 invalid 0011 fires", 1'b1);
    endtask

    task automatic t_irq_clear();
        logic [7:0] v;
        set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
        write_reg(4'h6, 8'h80);
        tick(8'h00, 8'h00, 8'h00, 8'h01);
        check_pin("R6 AE set drives pin", 1'b1);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 4'h0;
        #1;
        check_pin("R8 pin still low before edge", 1'b1);
        check8("R5 flag set", bus_rdata & 8'h40, 8'h40);
        @(negedge clk);
        #1;
        check_pin("R8 pin released during access", 1'b0);
        check8("R8 flag held during access", bus_rdata & 8'h40, 8'h40);
        bus_sel = 1'b0; bus_rd = 1'b0;
        @(negedge clk);
        read_reg(4'h0, v); check8("R8 flag clear after access", v, 8'h00);
        @(negedge clk);
        tick(8'h00, 8'h00, 8'h00, 8'h01);
        check_pin("R6 pin low again", 1'b1);
        write_reg(4'h0, 8'h00);
        #1 check_pin("R8 flags write releases pin", 1'b0);
        @(negedge clk);
        write_reg(4'h6, 8'h00);
    endtask

    task automatic t_backup();
        clear_flags();
        backup_mode = 1'b1;
        write_reg(4'h6, 8'h80);
        tick(8'h00, 8'h00, 8'h00, 8'h01);
        check_pin("R7 backup without ABE", 1'b0);
        expect_flag("R5 flag set in backup", 1'b1);
        write_reg(4'h6, 8'hA0);
        tick(8'h01, 8'h00, 8'h00, 8'h01);
        check_pin("R7 backup with ABE", 1'b1);
        clear_flags();
        check_pin("R7 released after clear", 1'b0);
        backup_mode = 1'b0;
        write_reg(4'h6, 8'h00);
    endtask

    task automatic t_flags_reg();
        logic [7:0] v;
        clear_flags();
        wd_flag = 1'b1; batt_low = 1'b1;
        write_reg(4'h0, 8'hFF);
        @(negedge clk);
        read_reg(4'h0, v); check8("R9 flags fixed bits", v, 8'h90);
        wd_flag = 1'b0; batt_low = 1'b0;
        @(negedge clk);
        read_reg(4'h0, v); check8("R9 write ignored", v, 8'h00);
    endtask

    task automatic t_freq_test();
        clear_flags();
        set_alarm(8'h00, 8'h00, 8'h00, 8'h00);
        @(negedge clk);
        ft_bit = 1'b1; wd_steer = 1'b1; wd_reg_zero = 1'b0;
        #1 check_pin("R10 starts released", 1'b0);
        pulse_1k(); check_pin("R10 toggle 1", 1'b1);
        pulse_1k(); check_pin("R10 toggle 2", 1'b0);
        pulse_1k(); check_pin("R10 toggle 3", 1'b1);
        @(negedge clk);
        wd_steer = 1'b0;
        #1 check_pin("R10 no steer no zero off", 1'b0);
        pulse_1k(); check_pin("R10 off ignores strobe", 1'b0);
        @(negedge clk);
        wd_reg_zero = 1'b1;
        pulse_1k(); check_pin("R10 via zero watchdog", 1'b1);
        write_reg(4'h6, 8'h80);
        #1 check_pin("R10 AE blocks test wave", 1'b0);
        pulse_1k(); check_pin("R10 AE blocks strobe", 1'b0);
        ft_bit = 1'b0; wd_reg_zero = 1'b0;
        write_reg(4'h6, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failed++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_masks();
        t_invalid();
        t_irq_clear();
        t_backup();
        t_flags_reg();
        t_freq_test();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule